// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block is the coherence controller for one processor's cache on a shared, atomic snooping bus. The cache is direct-mapped and write-back, and each line is one data word. Every line is in one of three states: Invalid, Shared or Modified. Reads to valid lines complete at once. Writes to Modified lines also complete at once. Any other access is a fault. On a fault the controller requests the bus. Once the arbiter grants the bus, the controller broadcasts a read miss, a write miss or an invalidate, then waits for the external memory to signal completion.

The controller also watches the transactions that other caches put on the bus. It demotes or invalidates its own copy as required, and it writes out the line's data when that copy is Modified. The main concern is the race between a local fault and remote traffic. The local line state never moves towards ownership before the bus is granted. If a conflicting snoop lands on the line frame of a request that is still waiting for the bus, the controller drops its bus request and evaluates the access again from the beginning.

The processor port uses a valid/ready handshake. The processor raises `cpu_valid` and holds the address, write flag and data stable until it sees `cpu_ready` high at a clock edge; that edge completes the access. `cpu_ready` stays low for the whole of a miss, including any victim write-back, and during any cycle in which a snoop is presented. Read data on `cpu_rdata` is valid in the cycle where `cpu_ready` is high.

Top module: `snoop_wb_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `bus_valid` and `flush_valid` are low, and `cpu_ready` stays low for any access until a fill has taken place.
- R2: A read to a valid line with a matching tag, or a write to a Modified line with a matching tag, has `cpu_ready` high in the same cycle. Read data comes from the line, and `bus_req` stays low.
- R3: A read fault raises `bus_req` in the cycle after the access is presented. The cycle after a grant, `bus_valid` is high with `bus_op` = 1 (read miss) and the request address. After `bus_done` the line is Shared and holds `bus_rdata`, and `cpu_ready` is high in the next cycle.
- R4: A write to a Shared line with a matching tag broadcasts `bus_op` = 3 (invalidate). A write to any other non-Modified line broadcasts `bus_op` = 2 (write miss). Either way the line ends Modified and holds the written data.
- R5: While a request waits for the grant, the state of its line does not change unless a snoop changes it. In particular, a pending write to a Shared line does not make that line Modified before the grant.
- R6: A snoop with `snp_op` 1, 2 or 3 whose address index (the low index bits) equals that of a waiting request drops `bus_req` in the next cycle. The request is then re-evaluated, so an upgrade whose Shared copy was invalidated is broadcast as a write miss.
- R7: A snooped read miss (`snp_op` = 1) that hits a Modified line pulses `flush_valid` one cycle later, with the snooped address and the line's data, and leaves the line Shared.
- R8: A snooped write miss or invalidate (`snp_op` 2 or 3) that hits a line moves the line to Invalid. If the line was Modified, it pulses `flush_valid` with the data first; if it was Shared, there is no flush.
- R9: A fault on a frame whose Modified line has a different tag first broadcasts `bus_op` = 4 (write-back), with the victim's address and data. In the same bus tenure it then broadcasts the miss for the new address.
- R10: A snoop whose tag does not match, or whose `snp_op` is 4, changes no line and produces no flush.
- R11: `cpu_ready` is low in every cycle in which `snp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits are the index |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted, held for the whole tenure |
| bus_valid | output | 1 | Transaction driven on the bus |
| bus_op | output | 3 | 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data from memory |
| bus_done | input | 1 | Current transaction finished |
| snp_valid | input | 1 | Foreign transaction observed |
| snp_op | input | 3 | Foreign transaction code, same encoding as bus_op |
| snp_addr | input | ADDR_W | Foreign transaction address |
| flush_valid | output | 1 | Dirty data supplied for a snoop |
| flush_addr | output | ADDR_W | Address of the supplied data |
| flush_data | output | DATA_W | Supplied data |

## Verification
The hardest situation to create is a snoop that arrives on the line frame of a request after the request has raised `bus_req` but before the arbiter grants the bus. The bench plays the arbiter, so it simply withholds `bus_gnt` and injects the foreign transaction in that window. It then checks that the request is withdrawn and raised again, and which bus operation the re-evaluated request broadcasts. The victim write-back case is reached by first making a line Modified, then faulting on another address that maps to the same frame.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'b00,
    LS_S = 2'b01,
    LS_M = 2'b10
  } line_st_e;

  typedef enum logic [2:0] {
    BOP_NONE = 3'd0,
    BOP_RD   = 3'd1,
    BOP_WR   = 3'd2,
    BOP_INV  = 3'd3,
    BOP_WB   = 3'd4
  } bus_op_e;
endpackage

// File: rtl/snp_line_array.sv
module snp_line_array #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int NPORT  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORT-1:0][IDX_W-1:0]    rd_idx,
  output logic [NPORT-1:0][1:0]          rd_st,
  output logic [NPORT-1:0][TAG_W-1:0]    rd_tag,
  output logic [NPORT-1:0][DATA_W-1:0]   rd_data,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [1:0]                     wr_st,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [DATA_W-1:0]              wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [1:0]        st_mem   [LINES];
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= snp_pkg::LS_I;
    end else if (wr_en) begin
      st_mem[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rd_st[p]   = st_mem[rd_idx[p]];
    assign rd_tag[p]  = tag_mem[rd_idx[p]];
    assign rd_data[p] = data_mem[rd_idx[p]];
  end
endmodule

// File: rtl/snp_snoop_resp.sv
module snp_snoop_resp #(
  parameter int TAG_W = 6
) (
  input  logic             snp_act,
  input  logic [2:0]       snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [1:0]       line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             upd,
  output logic [1:0]       new_st,
  output logic             flush
);
  import snp_pkg::*;
  logic hit;
  assign hit = snp_act && (line_st != LS_I) && (line_tag == snp_tag);

  always_comb begin
    upd    = 1'b0;
    new_st = line_st;
    flush  = 1'b0;
    if (hit) begin
      case (snp_op)
        BOP_RD: begin
          if (line_st == LS_M) begin
            upd    = 1'b1;
            new_st = LS_S;
            flush  = 1'b1;
          end
        end
        BOP_WR, BOP_INV: begin
          upd    = 1'b1;
          new_st = LS_I;
          flush  = (line_st == LS_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wb_ctrl.sv
module snoop_wb_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [2:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              snp_valid,
  input  logic [2:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);
  import snp_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NPORT = 3;
  localparam int PC = 0;
  localparam int PS = 1;
  localparam int PR = 2;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_XFER} fsm_e;

  fsm_e              st_q;
  bus_op_e           op_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;

  logic [IDX_W-1:0] cpu_idx, snp_idx, req_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag, req_tag;
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  logic [NPORT-1:0][IDX_W-1:0]  ap_idx;
  logic [NPORT-1:0][1:0]        ap_st;
  logic [NPORT-1:0][TAG_W-1:0]  ap_tag;
  logic [NPORT-1:0][DATA_W-1:0] ap_data;
  assign ap_idx[PC] = cpu_idx;
  assign ap_idx[PS] = snp_idx;
  assign ap_idx[PR] = req_idx;

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [1:0]       wr_st;
  logic [TAG_W-1:0] wr_tag;
  logic [DATA_W-1:0] wr_data;

  snp_line_array #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .NPORT(NPORT)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ap_idx), .rd_st(ap_st), .rd_tag(ap_tag), .rd_data(ap_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  logic       snp_act, snp_upd, snp_flush;
  logic [1:0] snp_new_st;
  assign snp_act = snp_valid && (st_q != FS_XFER);

  snp_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_act(snp_act), .snp_op(snp_op), .snp_tag(snp_tag),
    .line_st(ap_st[PS]), .line_tag(ap_tag[PS]),
    .upd(snp_upd), .new_st(snp_new_st), .flush(snp_flush)
  );

  // Local access classification
  logic cpu_hit;
  assign cpu_hit = (ap_st[PC] != LS_I) && (ap_tag[PC] == cpu_tag) &&
                   (!cpu_we || ap_st[PC] == LS_M);
  assign cpu_ready = (st_q == FS_IDLE) && !snp_valid && cpu_hit;
  assign cpu_rdata = ap_data[PC];

  // Pending request classification
  logic    req_tag_hit, victim_dirty;
  bus_op_e miss_op;
  assign req_tag_hit  = (ap_st[PR] != LS_I) && (ap_tag[PR] == req_tag);
  assign victim_dirty = (ap_st[PR] == LS_M) && (ap_tag[PR] != req_tag);
  assign miss_op = !req_we_q ? BOP_RD : (req_tag_hit ? BOP_INV : BOP_WR);

  logic waiting, restart;
  assign waiting = (st_q == FS_REQ);
  assign restart = waiting && snp_valid && (snp_idx == req_idx) &&
                   (snp_op == BOP_RD || snp_op == BOP_WR || snp_op == BOP_INV);

  // Single write port, snoop first
  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = cpu_idx;
    wr_st   = LS_M;
    wr_tag  = cpu_tag;
    wr_data = cpu_wdata;
    if (snp_act && snp_upd) begin
      wr_en   = 1'b1;
      wr_idx  = snp_idx;
      wr_st   = snp_new_st;
      wr_tag  = ap_tag[PS];
      wr_data = ap_data[PS];
    end else if (cpu_valid && cpu_ready && cpu_we) begin
      wr_en = 1'b1;
    end else if (st_q == FS_XFER && bus_done) begin
      wr_en  = 1'b1;
      wr_idx = req_idx;
      wr_tag = req_tag;
      case (op_q)
        BOP_WB: begin
          wr_st   = LS_I;
          wr_tag  = ap_tag[PR];
          wr_data = ap_data[PR];
        end
        BOP_RD: begin
          wr_st   = LS_S;
          wr_data = bus_rdata;
        end
        BOP_WR: begin
          wr_st   = LS_M;
          wr_data = bus_rdata;
        end
        default: begin
          wr_st   = LS_M;
          wr_data = ap_data[PR];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= FS_IDLE;
      op_q       <= BOP_NONE;
      req_addr_q <= '0;
      req_we_q   <= 1'b0;
    end else begin
      case (st_q)
        FS_IDLE: begin
          if (cpu_valid && !snp_valid && !cpu_hit) begin
            st_q       <= FS_REQ;
            req_addr_q <= cpu_addr;
            req_we_q   <= cpu_we;
          end
        end
        FS_REQ: begin
          if (restart) begin
            st_q <= FS_IDLE;
          end else if (bus_gnt) begin
            st_q <= FS_XFER;
            op_q <= victim_dirty ? BOP_WB : miss_op;
          end
        end
        default: begin
          if (bus_done) begin
            if (op_q == BOP_WB) begin
              op_q <= miss_op;
            end else begin
              st_q <= FS_IDLE;
              op_q <= BOP_NONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_valid <= 1'b0;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      flush_valid <= snp_act && snp_flush;
      if (snp_act && snp_flush) begin
        flush_addr <= snp_addr;
        flush_data <= ap_data[PS];
      end
    end
  end

  assign bus_req   = (st_q != FS_IDLE);
  assign bus_valid = (st_q == FS_XFER);
  assign bus_op    = (st_q == FS_XFER) ? op_q : BOP_NONE;
  assign bus_addr  = (op_q == BOP_WB) ? {ap_tag[PR], req_idx} : req_addr_q;
  assign bus_wdata = ap_data[PR];
endmodule

// File: rtl/snoop_wb_ctrl_chk.sv
module snoop_wb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_valid,
  input logic       bus_gnt,
  input logic       flush_valid,
  input logic       waiting,
  input logic       restart,
  input logic [1:0] req_line_st
);
  AST_WAIT_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !snp_valid) |=> $stable(req_line_st)); // R5
  AST_BUS_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt); // R3
  AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready); // R11
  AST_FLUSH_FOLLOWS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snp_valid)); // R7
  AST_RESTART_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bus_req); // R6
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req); // R2
endmodule

bind snoop_wb_ctrl snoop_wb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_valid(bus_valid), .bus_gnt(bus_gnt),
  .flush_valid(flush_valid), .waiting(waiting), .restart(restart),
  .req_line_st(ap_st[2])
);

// File: tb/test_snoop_wb_ctrl.sv
module test_snoop_wb_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_ADR = 8'h05;  // index 1, tag 1
  localparam logic [AW-1:0] B_ADR = 8'h12;  // index 2
  localparam logic [AW-1:0] C_ADR = 8'h0D;  // index 1, tag 3
  localparam logic [AW-1:0] X_ADR = 8'h45;  // index 1, other tag

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_valid;
  logic bus_gnt = 1'b0, bus_done = 1'b0;
  logic [2:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [2:0] snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic flush_valid;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  snoop_wb_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) i_snoop_wb_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cpu_start(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic wait_req(string rq);
    for (int i = 0; i < 8 && !bus_req; i++) tick();
    chk(rq, "bus_req", bus_req, 1);
  endtask

  // One transaction in the XFER state: check it, then complete it
  task automatic xfer_step(string rq, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] rd);
    chk(rq, "bus_valid", bus_valid, 1);
    chk(rq, "bus_op", bus_op, op);
    chk(rq, "bus_addr", bus_addr, a);
    bus_done = 1'b1; bus_rdata = rd;
    tick();
    bus_done = 1'b0;
  endtask

  task automatic finish_cpu(string rq, logic check_rd, logic [DW-1:0] exp_rd);
    chk(rq, "cpu_ready", cpu_ready, 1);
    if (check_rd) chk(rq, "cpu_rdata", cpu_rdata, exp_rd);
    tick();
    cpu_valid = 1'b0;
  endtask

  task automatic access_miss(string rq, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                             logic [2:0] op, logic [DW-1:0] fill);
    cpu_start(we, a, d);
    tick();
    wait_req(rq);
    bus_gnt = 1'b1;
    tick();
    xfer_step(rq, op, a, fill);
    bus_gnt = 1'b0;
    finish_cpu(rq, !we, fill);
  endtask

  task automatic access_hit(string rq, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                            logic [DW-1:0] exp_rd);
    cpu_start(we, a, d);
    #1;
    chk(rq, "hit bus_req", bus_req, 0);
    finish_cpu(rq, !we, exp_rd);
  endtask

  task automatic snoop(string rq, logic [2:0] op, logic [AW-1:0] a,
                       logic exp_flush, logic [DW-1:0] exp_data);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    tick();
    snp_valid = 1'b0;
    chk(rq, "flush_valid", flush_valid, exp_flush);
    if (exp_flush) begin
      chk(rq, "flush_addr", flush_addr, a);
      chk(rq, "flush_data", flush_data, exp_data);
    end
    tick();
    chk(rq, "flush_valid drop", flush_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "bus_valid", bus_valid, 0);
    chk("R1", "flush_valid", flush_valid, 0);
    cpu_start(1'b0, A_ADR, '0);
    #1;
    chk("R1", "cpu_ready on empty cache", cpu_ready, 0);
    cpu_valid = 1'b0;
    tick();
    chk("R1", "no request once dropped", bus_req, 0);
  endtask

  task automatic t_read_miss_then_hit();
    access_miss("R3", 1'b0, A_ADR, '0, 3'd1, 32'hA5A5_0001);
    access_hit("R2", 1'b0, A_ADR, '0, 32'hA5A5_0001);
  endtask

  task automatic t_writes();
    access_miss("R4", 1'b1, A_ADR, 32'h1111_2222, 3'd3, 32'h0);
    access_hit("R2", 1'b0, A_ADR, '0, 32'h1111_2222);
    access_miss("R4", 1'b1, B_ADR, 32'h2222_3333, 3'd2, 32'hBBBB_0000);
    access_hit("R4", 1'b0, B_ADR, '0, 32'h2222_3333);
  endtask

  task automatic t_snoop_read_m();
    snoop("R7", 3'd1, A_ADR, 1'b1, 32'h1111_2222);
    access_miss("R7", 1'b1, A_ADR, 32'h3333_4444, 3'd3, 32'h0); // Shared now
  endtask

  task automatic t_snoop_kill();
    snoop("R8", 3'd2, A_ADR, 1'b1, 32'h3333_4444);
    access_miss("R8", 1'b0, A_ADR, '0, 3'd1, 32'hA5A5_0002);
    snoop("R8", 3'd3, A_ADR, 1'b0, '0);
    access_miss("R8", 1'b0, A_ADR, '0, 3'd1, 32'hA5A5_0003);
  endtask

  task automatic t_ignored();
    snoop("R10", 3'd1, X_ADR, 1'b0, '0);
    access_hit("R10", 1'b0, A_ADR, '0, 32'hA5A5_0003);
    snoop("R10", 3'd4, B_ADR, 1'b0, '0);
    access_hit("R10", 1'b1, B_ADR, 32'h7777_0000, '0);
    access_hit("R10", 1'b0, B_ADR, '0, 32'h7777_0000);
  endtask

  task automatic t_snoop_priority();
    snp_valid = 1'b1; snp_op = 3'd1; snp_addr = X_ADR;
    cpu_start(1'b0, A_ADR, '0);
    #1;
    chk("R11", "cpu_ready during snoop", cpu_ready, 0);
    tick();
    snp_valid = 1'b0;
    #1;
    chk("R11", "bus_req after snoop", bus_req, 0);
    finish_cpu("R11", 1'b1, 32'hA5A5_0003);
  endtask

  task automatic t_restart_keep();
    cpu_start(1'b1, A_ADR, 32'h4444_0000);
    tick();
    wait_req("R6");
    snp_valid = 1'b1; snp_op = 3'd1; snp_addr = A_ADR;
    tick();
    snp_valid = 1'b0;
    chk("R5", "no flush, line not yet Modified", flush_valid, 0);
    chk("R6", "bus_req dropped", bus_req, 0);
    tick();
    chk("R6", "bus_req raised again", bus_req, 1);
    bus_gnt = 1'b1;
    tick();
    xfer_step("R5", 3'd3, A_ADR, '0);
    bus_gnt = 1'b0;
    finish_cpu("R5", 1'b0, '0);
  endtask

  task automatic t_victim();
    cpu_start(1'b0, C_ADR, '0);
    tick();
    wait_req("R9");
    bus_gnt = 1'b1;
    tick();
    chk("R9", "victim data", bus_wdata, 32'h4444_0000);
    xfer_step("R9", 3'd4, A_ADR, '0);
    xfer_step("R9", 3'd1, C_ADR, 32'hCCCC_0001);
    bus_gnt = 1'b0;
    finish_cpu("R9", 1'b1, 32'hCCCC_0001);
  endtask

  task automatic t_restart_upgrade();
    cpu_start(1'b1, C_ADR, 32'h5555_0000);
    tick();
    wait_req("R6");
    snp_valid = 1'b1; snp_op = 3'd2; snp_addr = C_ADR;
    tick();
    snp_valid = 1'b0;
    chk("R6", "no flush from Shared", flush_valid, 0);
    chk("R6", "bus_req dropped", bus_req, 0);
    tick();
    chk("R6", "bus_req raised again", bus_req, 1);
    bus_gnt = 1'b1;
    tick();
    xfer_step("R6", 3'd2, C_ADR, 32'hC0C1_0000);
    bus_gnt = 1'b0;
    finish_cpu("R6", 1'b0, '0);
    access_hit("R6", 1'b0, C_ADR, '0, 32'h5555_0000);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_read_miss_then_hit();
    t_writes();
    t_snoop_read_m();
    t_snoop_kill();
    t_ignored();
    t_snoop_priority();
    t_restart_keep();
    t_victim();
    t_restart_upgrade();
    repeat (2) tick();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule